// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches an external input pin and, when a selected kind of edge occurs, copies the current count of a free-running 16-bit timer into a capture register. Each capture also sets a sticky interrupt flag. The flag stays set until the processor pulses a clear strobe. The raw pin passes through a two-flop synchronizer. Edges are found by comparing successive synchronized samples, so at most one capture can happen per clock.

A 4-bit mode field selects what counts as an event. The choices are every falling edge, every rising edge, every fourth rising edge and every sixteenth rising edge. The divided modes share one 4-bit rising-edge counter. That counter is cleared by reset, when the unit is off, or when the mode is not a capture mode. Moving between the two divided ratios does not clear it, so the first capture after such a change can come early. A new capture overwrites an unread value without any warning, and changes of mode are passed through unfiltered.

Top module: `pin_capture`

## Requirements
- R1: Reset clears the captured value to 0, clears the flag and clears the prescaler counter. After reset in mode 4'b0110, the fourth rising edge is the first one to capture.
- R2: In mode 4'b0101, every rising edge of the pin causes a capture. A pin level set up before clock edge k is captured at clock edge k+2 with the timer value sampled at that edge.
- R3: In mode 4'b0100, every falling edge causes a capture and rising edges cause none.
- R4: In mode 4'b0110, every fourth rising edge causes a capture. This is measured from a cleared counter.
- R5: In mode 4'b0111, every sixteenth rising edge causes a capture. This is measured from a cleared counter.
- R6: The flag is set by every capture and stays set until a cycle with flag_clr high and no capture. That cycle clears it.
- R7: When flag_clr and a capture fall in the same cycle, the flag ends up set.
- R8: A capture overwrites the previous captured value even if that value was never read.
- R9: Mode 4'b0000 (off) and every mode outside 4'b0100 to 4'b0111 causes no capture and clears the prescaler counter.
- R10: Switching between 4'b0111 and 4'b0110 keeps the counter. Three rising edges in 4'b0111 followed by one in 4'b0110 produce a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw, unsynchronized event pin |
| timer_val | input | 16 | Current timer count |
| mode | input | 4 | Event selection field |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_val | output | 16 | Captured timer value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench goes after the prescaler boundaries. If the count wrapped at the wrong point, a capture would come one edge early or late in the divide-by-4 or divide-by-16 runs. The bench also checks that reset and leaving capture mode clear the counter, while a ratio switch must not; a design that got this wrong would miss the early capture after the switch, or would capture early after re-entry. The tests of a clear strobe that coincides with a capture and of overwriting an unread value catch a design that gives clear priority or refuses to overwrite. The falling-edge run shows up a design that mixes up the edge polarity.

// File: rtl/pin_capture.sv
module pin_capture #(
  parameter int TW   = 16,
  parameter int SYNC = 2,
  parameter int PW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [TW-1:0] timer_val,
  input  logic [3:0]    mode,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag
);
  localparam logic [3:0] M_FALL  = 4'b0100;
  localparam logic [3:0] M_RISE  = 4'b0101;
  localparam logic [3:0] M_DIV4  = 4'b0110;
  localparam logic [3:0] M_DIV16 = 4'b0111;
  localparam int D4W = 2;

  logic [SYNC:0] sh;
  logic [PW-1:0] cnt;
  logic [PW-1:0] cnt_nx;
  logic rise, fall, cap_mode, pre_mode, fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pin_in};

  assign rise     = sh[SYNC-1] & ~sh[SYNC];
  assign fall     = ~sh[SYNC-1] & sh[SYNC];
  assign cap_mode = (mode[3:2] == 2'b01);
  assign pre_mode = (mode == M_DIV4) || (mode == M_DIV16);
  assign cnt_nx   = cnt + 1'b1;

  assign fire = ((mode == M_FALL)  && fall) ||
                ((mode == M_RISE)  && rise) ||
                ((mode == M_DIV4)  && rise && (cnt_nx[D4W-1:0] == '0)) ||
                ((mode == M_DIV16) && rise && (cnt_nx == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (!cap_mode)        cnt <= '0;
    else if (pre_mode && rise) cnt <= cnt_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cap_val <= '0;
    else if (fire) cap_val <= timer_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cap_flag <= 1'b0;
    else if (fire)     cap_flag <= 1'b1;
    else if (flag_clr) cap_flag <= 1'b0;
endmodule

// File: rtl/pin_capture_chk.sv
module pin_capture_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] timer_val,
  input logic [3:0]    mode,
  input logic          flag_clr,
  input logic [TW-1:0] cap_val,
  input logic          cap_flag,
  input logic          fire,
  input logic          rise,
  input logic          fall
);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  a_r6_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_val) |-> cap_flag);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && flag_clr) |=> cap_flag);

  a_r8_loads_timer: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cap_val == $past(timer_val)));

  a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b0000) |=> ($stable(cap_val) && !$rose(cap_flag)));

  a_r3_falling_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == 4'b0100) |-> (fall && !rise));
endmodule

bind pin_capture pin_capture_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .mode(mode),
  .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag),
  .fire(fire), .rise(rise), .fall(fall)
);

// File: tb/test_pin_capture.sv
module test_pin_capture;
  logic clk = 0, rst_n = 0, pin_in = 0, flag_clr = 0;
  logic [15:0] timer_val = 0;
  logic [3:0]  mode = 0;
  logic [15:0] cap_val;
  logic        cap_flag;
  int n_chk = 0, n_fail = 0, caps = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_capture i_pin_capture (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_val(timer_val),
    .mode(mode), .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  // {mode, pulses, expected captures}; last pulse always captures when expected > 0
  localparam logic [13:0] VEC [0:7] = '{
    {4'b0101, 5'd5,  5'd5},   // R2
    {4'b0100, 5'd5,  5'd5},   // R3
    {4'b0110, 5'd8,  5'd2},   // R4
    {4'b0110, 5'd3,  5'd0},   // R4
    {4'b0111, 5'd16, 5'd1},   // R5
    {4'b0111, 5'd15, 5'd0},   // R5
    {4'b0000, 5'd4,  5'd0},   // R9
    {4'b1000, 5'd4,  5'd0}    // R9
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_pulse();
    @(negedge clk) flag_clr = 1;
    @(negedge clk) flag_clr = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    if (cap_flag) begin caps++; clr_pulse(); end
  endtask

  task automatic pulse(input logic [15:0] tv);
    @(negedge clk) begin timer_val = tv; pin_in = 1; end
    settle();
    @(negedge clk) pin_in = 0;
    settle();
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk) mode = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cap_val == 0, "R1 cap_val in reset", cap_val, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cap_val == 0 && cap_flag == 0, "R1 reset state", {cap_val, 15'd0, cap_flag}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [15:0] last;
      set_mode(4'b0000);
      set_mode(VEC[v][13:10]);
      caps = 0;
      last = 0;
      for (int i = 0; i < int'(VEC[v][9:5]); i++) begin
        last = 16'hA000 + 16'(v * 32 + i);
        pulse(last);
      end
      chk(caps == int'(VEC[v][4:0]), $sformatf("R2/R3/R4/R5/R9 vector %0d count", v), caps, VEC[v][4:0]);
      if (VEC[v][4:0] != 0)
        chk(cap_val == last, $sformatf("R2 vector %0d value", v), cap_val, last);
    end

    // R1: reset clears the prescaler counter
    set_mode(4'b0000);
    set_mode(4'b0110);
    pulse(16'h1111); pulse(16'h1112);
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    caps = 0;
    for (int i = 0; i < 3; i++) pulse(16'h2000 + 16'(i));
    chk(caps == 0, "R1 no capture before 4th edge after reset", caps, 0);
    pulse(16'h2222);
    chk(caps == 1 && cap_val == 16'h2222, "R1 4th edge after reset captures", cap_val, 16'h2222);

    // R9: leaving capture mode clears the counter
    set_mode(4'b0000);
    set_mode(4'b0110);
    pulse(16'h3001); pulse(16'h3002);
    set_mode(4'b1100);
    set_mode(4'b0110);
    caps = 0;
    for (int i = 0; i < 3; i++) pulse(16'h3100 + 16'(i));
    chk(caps == 0, "R9 counter cleared by non-capture mode", caps, 0);
    pulse(16'h3333);
    chk(caps == 1, "R9 capture on 4th edge after re-entry", caps, 1);

    // R10: ratio change keeps the counter
    set_mode(4'b0000);
    set_mode(4'b0111);
    caps = 0;
    for (int i = 0; i < 3; i++) pulse(16'h4000 + 16'(i));
    set_mode(4'b0110);
    pulse(16'h4444);
    chk(caps == 1 && cap_val == 16'h4444, "R10 early capture after ratio switch", cap_val, 16'h4444);

    // R6: sticky flag, clear without capture
    set_mode(4'b0101);
    @(negedge clk) begin timer_val = 16'h5555; pin_in = 1; end
    repeat (20) @(negedge clk);
    chk(cap_flag == 1, "R6 flag stays set", cap_flag, 1);
    clr_pulse();
    chk(cap_flag == 0, "R6 flag cleared by strobe", cap_flag, 0);

    // R8: overwrite without read
    @(negedge clk) pin_in = 0;
    repeat (4) @(negedge clk);
    @(negedge clk) begin timer_val = 16'h6001; pin_in = 1; end
    repeat (4) @(negedge clk);
    @(negedge clk) pin_in = 0;
    repeat (4) @(negedge clk);
    @(negedge clk) begin timer_val = 16'h6002; pin_in = 1; end
    repeat (4) @(negedge clk);
    chk(cap_val == 16'h6002, "R8 second capture overwrites", cap_val, 16'h6002);

    // R7: clear and capture in the same cycle
    @(negedge clk) pin_in = 0;
    repeat (4) @(negedge clk);
    chk(cap_flag == 1, "R7 flag set before test", cap_flag, 1);
    @(negedge clk) begin timer_val = 16'h7777; pin_in = 1; end  // before edge k
    @(negedge clk);                                              // after k
    @(negedge clk) flag_clr = 1;                                 // high at edge k+2
    @(negedge clk) flag_clr = 0;
    chk(cap_flag == 1 && cap_val == 16'h7777, "R7 set wins over clear", {cap_val, 15'd0, cap_flag}, {16'h7777, 16'h1});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule